// File: doc/BRIEF.md
# Multi-Process Paged Address Translator

This block translates virtual addresses for several processes that share one small physical memory. The virtual and physical spaces are both 1 KB and byte addressable, split into 128-byte pages. That gives eight virtual pages per process and eight physical frames, a 7-bit page offset and a 3-bit page number. Frame 0 belongs to the operating system. Every process owns a single-level page table that fills exactly one frame. Page-table frames and data frames are drawn from the same pool.

A request either creates the page table of a process or translates one access. On a translation miss the entry is written, and a frame is taken. The block picks the lowest-numbered free frame. When no frame is free, it takes the least recently used data frame of any process and invalidates the owner's entry. The fill of the new frame is handed to the outside through a fill strobe, and the block waits for a done pulse before it answers. The response carries the physical address, a fault flag, an error flag and the identity of any evicted page.

Top module: `paged_xlat`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and fill_valid are 0, no process has a page table, and frames 1 to 7 are free.
- R2: A translation that hits responds with rsp_valid for exactly one cycle, on the clock edge after the accepting edge, with rsp_fault 0 and rsp_pa equal to the mapped frame number (bits 9:7) concatenated with the unchanged offset (bits 6:0).
- R3: A create request (req_new = 1) for a process without a table places the table in the lowest free frame and returns that frame's base address. A repeated create returns the same address and changes nothing.
- R4: A translation miss for a process with a table picks the lowest free frame. It holds fill_valid with a stable fill_frame until fill_done, then responds with rsp_fault 1 and the address in the new frame.
- R5: Frame 0 is never allocated. A frame holding a page table is never evicted.
- R6: With no free frame, the least recently used data frame is taken regardless of owner. rsp_evict is 1, rsp_evict_pid and rsp_evict_vpn name the lost page, and a later access to that page faults.
- R7: A translation from a process without a page table responds with rsp_err 1 and rsp_pa 0. It leaves all mappings and frame assignments unchanged.
- R8: Both a hit and a fault fill make the frame the most recently used one.
- R9: Only one request is in flight at a time. req_ready is 0 from the accepting edge until the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_new | input | 1 | 1: create page table for req_pid; 0: translate req_va |
| req_pid | input | PID_W | Process identifier |
| req_va | input | VPN_W+OFF_W | Virtual address |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_pa | output | VPN_W+OFF_W | Physical address (table base for create) |
| rsp_fault | output | 1 | Translation missed and a frame was filled |
| rsp_err | output | 1 | Process has no page table |
| rsp_evict | output | 1 | A data page was evicted |
| rsp_evict_pid | output | PID_W | Owner of the evicted page |
| rsp_evict_vpn | output | VPN_W | Virtual page number of the evicted page |
| fill_valid | output | 1 | Frame fill pending |
| fill_frame | output | VPN_W | Frame being filled |
| fill_done | input | 1 | Fill finished |

## Verification
The hardest case to reach is an eviction that must skip page-table frames and pick the oldest data frame of another process. For this, every frame must be in use, and the recency order must be known. The stimulus fills all seven frames with a mix of tables and data pages from two processes. It then refreshes one old page by a hit, so that the victim differs from plain allocation order. A third process's table creation then forces eviction while an untouched table frame stays the oldest frame overall. Further faults then walk the victim choice through the remaining data frames.

// File: rtl/xlat_pkg.sv
// Shared types of the paged translator.
// Assumes: nothing beyond IEEE 1800-2017.
package xlat_pkg;
    typedef enum logic [1:0] {
        FK_FREE  = 2'd0,
        FK_OS    = 2'd1,
        FK_TABLE = 2'd2,
        FK_DATA  = 2'd3
    } frame_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_FILL = 2'd2
    } xlat_state_t;
endpackage

// File: rtl/xlat_pick_lowest.sv
// Priority encoder: returns the lowest set bit of a mask.
// Assumes: W is wide enough to index N entries.
module xlat_pick_lowest #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] mask,
    output logic         found,
    output logic [W-1:0] idx
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        found = |mask;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/xlat_lru.sv
// Per-frame age counters that keep a total recency order.
// A touch zeroes the frame's age and ages every younger frame by one.
// The victim is the oldest frame among the candidates.
// Assumes: N equals 2**W, so ages 0..N-1 form a permutation.
module xlat_lru #(
    parameter int N = 8,
    parameter int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         touch,
    input  logic [W-1:0] touch_idx,
    input  logic [N-1:0] cand,
    output logic         vic_found,
    output logic [W-1:0] vic_idx
);
    logic [W-1:0] age [N];
    logic [W-1:0] best;

    // Update the ages on a touch; reset gives each frame a distinct age.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) age[i] <= W'(i);
        end else if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (W'(i) == touch_idx)          age[i] <= '0;
                else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
            end
        end
    end

    // Pick the candidate with the largest age.
    always_comb begin
        vic_found = 1'b0;
        vic_idx   = '0;
        best      = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!vic_found || age[i] > best)) begin
                vic_found = 1'b1;
                vic_idx   = W'(i);
                best      = age[i];
            end
        end
    end

    assert_touch_mru_R8: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> age[$past(touch_idx)] == '0);
endmodule

// File: rtl/xlat_ptable.sv
// Page-table storage for all processes: a valid bit and a frame number per entry.
// The read port is combinational. The write and invalidate ports act at the clock edge.
// Assumes: write and invalidate never target the same entry in one cycle.
module xlat_ptable #(
    parameter int NPROC = 4,
    parameter int NPAGE = 8,
    parameter int FW    = 3,
    parameter int PW    = 2,
    parameter int VW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] rd_pid,
    input  logic [VW-1:0] rd_vpn,
    output logic          rd_hit,
    output logic [FW-1:0] rd_ppn,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_pid,
    input  logic [VW-1:0] wr_vpn,
    input  logic [FW-1:0] wr_ppn,
    input  logic          inv_en,
    input  logic [PW-1:0] inv_pid,
    input  logic [VW-1:0] inv_vpn
);
    logic [NPAGE-1:0] vld [NPROC];
    logic [FW-1:0]    ppn [NPROC][NPAGE];

    // Valid bits: cleared by reset, set by writes, cleared by evictions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NPROC; p++) vld[p] <= '0;
        end else begin
            if (inv_en) vld[inv_pid][inv_vpn] <= 1'b0;
            if (wr_en)  vld[wr_pid][wr_vpn]   <= 1'b1;
        end
    end

    // Frame numbers: written with the valid bit, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) ppn[wr_pid][wr_vpn] <= wr_ppn;
    end

    // Combinational lookup.
    assign rd_hit = vld[rd_pid][rd_vpn];
    assign rd_ppn = ppn[rd_pid][rd_vpn];

    assert_inv_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en |-> vld[inv_pid][inv_vpn]);
    assert_wr_fresh_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !vld[wr_pid][wr_vpn]);
endmodule

// File: rtl/paged_xlat.sv
// Multi-process paged address translator with frame allocation.
// Handles one request at a time: accept, execute, then an optional wait for
// the frame fill. Page tables and data pages share the frame pool. Frame 0 is
// reserved. Free frames are taken lowest first, otherwise the least recently
// used data frame of any process is evicted.
// Assumes: NPROC <= NFRAME - 2, so a data frame always exists when none is free.
module paged_xlat #(
    parameter int PID_W = 2,
    parameter int VPN_W = 3,
    parameter int OFF_W = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_new,
    input  logic [PID_W-1:0]       req_pid,
    input  logic [VPN_W+OFF_W-1:0] req_va,
    output logic                   rsp_valid,
    output logic [VPN_W+OFF_W-1:0] rsp_pa,
    output logic                   rsp_fault,
    output logic                   rsp_err,
    output logic                   rsp_evict,
    output logic [PID_W-1:0]       rsp_evict_pid,
    output logic [VPN_W-1:0]       rsp_evict_vpn,
    output logic                   fill_valid,
    output logic [VPN_W-1:0]       fill_frame,
    input  logic                   fill_done
);
    import xlat_pkg::*;

    localparam int VA_W   = VPN_W + OFF_W;
    localparam int NPROC  = 1 << PID_W;
    localparam int NFRAME = 1 << VPN_W;
    localparam int FW     = VPN_W;

    xlat_state_t          st;
    logic                 new_q;
    logic [PID_W-1:0]     pid_q;
    logic [VA_W-1:0]      va_q;
    frame_kind_t          fk    [NFRAME];
    logic [PID_W-1:0]     f_pid [NFRAME];
    logic [VPN_W-1:0]     f_vpn [NFRAME];
    logic [NPROC-1:0]     tbl_ok;
    logic [FW-1:0]        tbl_frm [NPROC];

    logic [NFRAME-1:0]    free_mask, data_mask;
    logic                 free_found, vic_found;
    logic [FW-1:0]        free_idx, vic_idx, alloc_frm;
    logic [VPN_W-1:0]     vpn_q;
    logic [OFF_W-1:0]     off_q, off_sel;
    logic                 pt_hit;
    logic [FW-1:0]        pt_ppn;
    logic                 has_tbl, need_alloc, miss, do_evict, in_exec;
    logic                 touch;
    logic [FW-1:0]        touch_frm, pa_frame;

    // Per-frame classification masks.
    for (genvar f = 0; f < NFRAME; f++) begin : g_mask
        assign free_mask[f] = (fk[f] == FK_FREE);
        assign data_mask[f] = (fk[f] == FK_DATA);
    end

    xlat_pick_lowest #(.N(NFRAME), .W(FW)) u_pick (
        .mask  (free_mask),
        .found (free_found),
        .idx   (free_idx)
    );

    xlat_lru #(.N(NFRAME), .W(FW)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (touch),
        .touch_idx (touch_frm),
        .cand      (data_mask),
        .vic_found (vic_found),
        .vic_idx   (vic_idx)
    );

    xlat_ptable #(.NPROC(NPROC), .NPAGE(NFRAME), .FW(FW), .PW(PID_W), .VW(VPN_W)) u_pt (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_pid  (pid_q),
        .rd_vpn  (vpn_q),
        .rd_hit  (pt_hit),
        .rd_ppn  (pt_ppn),
        .wr_en   (in_exec && miss),
        .wr_pid  (pid_q),
        .wr_vpn  (vpn_q),
        .wr_ppn  (alloc_frm),
        .inv_en  (in_exec && do_evict),
        .inv_pid (f_pid[alloc_frm]),
        .inv_vpn (f_vpn[alloc_frm])
    );

    // Decode the latched request into allocation and response decisions.
    always_comb begin
        vpn_q      = va_q[VA_W-1:OFF_W];
        off_q      = va_q[OFF_W-1:0];
        in_exec    = (st == ST_EXEC);
        has_tbl    = tbl_ok[pid_q];
        miss       = !new_q && has_tbl && !pt_hit;
        need_alloc = (new_q && !has_tbl) || miss;
        alloc_frm  = free_found ? free_idx : vic_idx;
        do_evict   = need_alloc && !free_found;
        touch      = in_exec && !new_q && has_tbl;
        touch_frm  = pt_hit ? pt_ppn : alloc_frm;
        if (new_q) pa_frame = has_tbl ? tbl_frm[pid_q] : alloc_frm;
        else       pa_frame = touch_frm;
        off_sel    = new_q ? '0 : off_q;
    end

    assign req_ready = (st == ST_IDLE);

    // Request sequencing, frame bookkeeping and registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st            <= ST_IDLE;
            new_q         <= 1'b0;
            pid_q         <= '0;
            va_q          <= '0;
            tbl_ok        <= '0;
            rsp_valid     <= 1'b0;
            rsp_pa        <= '0;
            rsp_fault     <= 1'b0;
            rsp_err       <= 1'b0;
            rsp_evict     <= 1'b0;
            rsp_evict_pid <= '0;
            rsp_evict_vpn <= '0;
            fill_valid    <= 1'b0;
            fill_frame    <= '0;
            for (int f = 0; f < NFRAME; f++) begin
                fk[f]    <= (f == 0) ? FK_OS : FK_FREE;
                f_pid[f] <= '0;
                f_vpn[f] <= '0;
            end
            for (int p = 0; p < NPROC; p++) tbl_frm[p] <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        new_q <= req_new;
                        pid_q <= req_pid;
                        va_q  <= req_va;
                        st    <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    rsp_err       <= !new_q && !has_tbl;
                    rsp_fault     <= miss;
                    rsp_evict     <= do_evict;
                    rsp_evict_pid <= do_evict ? f_pid[alloc_frm] : '0;
                    rsp_evict_vpn <= do_evict ? f_vpn[alloc_frm] : '0;
                    rsp_pa        <= (!new_q && !has_tbl) ? '0 : {pa_frame, off_sel};
                    if (need_alloc) begin
                        fk[alloc_frm]    <= new_q ? FK_TABLE : FK_DATA;
                        f_pid[alloc_frm] <= pid_q;
                        f_vpn[alloc_frm] <= vpn_q;
                    end
                    if (new_q && !has_tbl) begin
                        tbl_ok[pid_q]  <= 1'b1;
                        tbl_frm[pid_q] <= alloc_frm;
                    end
                    if (miss) begin
                        fill_valid <= 1'b1;
                        fill_frame <= alloc_frm;
                        st         <= ST_FILL;
                    end else begin
                        rsp_valid <= 1'b1;
                        st        <= ST_IDLE;
                    end
                end
                ST_FILL: begin
                    if (fill_done) begin
                        fill_valid <= 1'b0;
                        rsp_valid  <= 1'b1;
                        st         <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> !req_ready);
    assert_rsp_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_no_frame0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_err) |-> rsp_pa[VA_W-1:OFF_W] != '0);
    assert_fill_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fill_done) |=> (fill_valid && $stable(fill_frame)));
    assert_evict_only_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_evict) |-> free_mask == '0);
    assert_victim_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && do_evict) |-> (vic_found && fk[vic_idx] == FK_DATA));
    assert_err_no_alloc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (!rsp_fault && !rsp_evict));
endmodule

// File: tb/paged_xlat_tb.sv
// Directed bench: one task per scenario, each checks its own responses.
module paged_xlat_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_new = 1'b0;
    logic [1:0] req_pid = '0;
    logic [9:0] req_va = '0;
    logic       rsp_valid;
    logic [9:0] rsp_pa;
    logic       rsp_fault, rsp_err, rsp_evict;
    logic [1:0] rsp_evict_pid;
    logic [2:0] rsp_evict_vpn;
    logic       fill_valid;
    logic [2:0] fill_frame;
    logic       fill_done = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    paged_xlat u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_new(req_new),
        .req_pid(req_pid), .req_va(req_va),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
        .rsp_err(rsp_err), .rsp_evict(rsp_evict),
        .rsp_evict_pid(rsp_evict_pid), .rsp_evict_vpn(rsp_evict_vpn),
        .fill_valid(fill_valid), .fill_frame(fill_frame), .fill_done(fill_done)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // One request; answers the fill after three cycles and checks the response.
    task automatic txn(input string tag, input logic nw, input logic [1:0] pid,
                       input logic [9:0] va, input logic [9:0] epa, input logic efault,
                       input logic eerr, input logic eev, input logic [1:0] epid,
                       input logic [2:0] evpn);
        int  nfill = 0;
        bit  got = 0;
        @(negedge clk);
        req_valid = 1'b1; req_new = nw; req_pid = pid; req_va = va;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9", "ready after accept", req_ready, 0);
        for (int c = 0; c < 40 && !got; c++) begin
            @(negedge clk);
            fill_done = 1'b0;
            if (rsp_valid) begin
                got = 1;
                check(tag, "pa", rsp_pa, epa);
                check(tag, "fault", rsp_fault, efault);
                check(tag, "err", rsp_err, eerr);
                check(tag, "evict", rsp_evict, eev);
                if (eev) begin
                    check(tag, "evict pid", rsp_evict_pid, epid);
                    check(tag, "evict vpn", rsp_evict_vpn, evpn);
                end
            end else if (fill_valid) begin
                nfill++;
                check("R4", "fill frame", fill_frame, epa[9:7]);
                check("R9", "ready during fill", req_ready, 0);
                if (nfill == 3) fill_done = 1'b1;
            end
        end
        check(tag, "response seen", got, 1);
        check(tag, "fill cycles", nfill, efault ? 3 : 0);
        @(negedge clk);
        check("R2", "single-cycle response", rsp_valid, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", "ready", req_ready, 1);
        check("R1", "rsp_valid", rsp_valid, 0);
        check("R1", "fill_valid", fill_valid, 0);
    endtask

    task automatic t_no_table();
        // R7: pid 0 has no table yet; the first create still gets frame 1.
        txn("R7", 0, 2'd0, 10'h28A, 10'h000, 0, 1, 0, 0, 0);
    endtask

    task automatic t_create();
        txn("R3", 1, 2'd0, 10'h055, 10'h080, 0, 0, 0, 0, 0);
        txn("R3", 1, 2'd0, 10'h000, 10'h080, 0, 0, 0, 0, 0);
    endtask

    task automatic t_fill_lowest();
        txn("R4", 0, 2'd0, 10'h28A, 10'h10A, 1, 0, 0, 0, 0);
        txn("R2", 0, 2'd0, 10'h29B, 10'h11B, 0, 0, 0, 0, 0);
        txn("R3", 1, 2'd1, 10'h000, 10'h180, 0, 0, 0, 0, 0);
        txn("R4", 0, 2'd1, 10'h28A, 10'h20A, 1, 0, 0, 0, 0);
        txn("R4", 0, 2'd0, 10'h094, 10'h294, 1, 0, 0, 0, 0);
        txn("R7", 0, 2'd3, 10'h094, 10'h000, 0, 1, 0, 0, 0);
        txn("R4", 0, 2'd1, 10'h1FF, 10'h37F, 1, 0, 0, 0, 0);
        txn("R4", 0, 2'd0, 10'h010, 10'h390, 1, 0, 0, 0, 0);
    endtask

    task automatic t_evict_lru();
        // R8: this hit refreshes frame 2, so frame 4 becomes the oldest data frame.
        txn("R8", 0, 2'd0, 10'h28A, 10'h10A, 0, 0, 0, 0, 0);
        txn("R6", 0, 2'd1, 10'h300, 10'h200, 1, 0, 1, 2'd1, 3'd5);
        txn("R6", 0, 2'd1, 10'h28A, 10'h28A, 1, 0, 1, 2'd0, 3'd1);
    endtask

    task automatic t_pinned();
        // R5: table frames 1 and 3 stay untouched; only data frames are taken.
        txn("R5", 1, 2'd2, 10'h000, 10'h300, 0, 0, 1, 2'd1, 3'd3);
        txn("R5", 0, 2'd2, 10'h07F, 10'h3FF, 1, 0, 1, 2'd0, 3'd0);
        txn("R6", 0, 2'd1, 10'h1FF, 10'h17F, 1, 0, 1, 2'd0, 3'd5);
        txn("R6", 0, 2'd0, 10'h28A, 10'h20A, 1, 0, 1, 2'd1, 3'd6);
        txn("R2", 0, 2'd1, 10'h28A, 10'h28A, 0, 0, 0, 0, 0);
        txn("R3", 1, 2'd0, 10'h000, 10'h080, 0, 0, 0, 0, 0);
    endtask

    initial begin
        t_reset();
        t_no_table();
        t_create();
        t_fill_lowest();
        t_evict_lru();
        t_pinned();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule